// File: doc/BRIEF.md
# Duplex Processor Watchdog with Failover

This block supervises two processors that share one bus, only one of which is in control at a time. The processor in control must keep proving it is alive by writing a fixed key to a kick register before a countdown runs out. If the countdown reaches its end without a valid kick, the block disables the processor in control, enables the standby processor and lights a CPU-fault indicator. The countdown then restarts for the new processor. If that one also misses its deadline, both processors are held disabled and a fatal flag is raised.

Software running self-tests on the processor in control can report a detected fault by writing to a second register. That write lights a separate self-test indicator. Every indicator and the failover state are sticky. Only a pulse on the operator clear input returns control to the primary processor and clears them. The timeout period is a cycle count taken from an input once, just after reset.

Top module: `wdt_failover`

## Requirements
- R1: After reset, `cpu_dis_o` is 2'b10 (bit 0 disables the primary, bit 1 disables the standby), `active_o` is 0, and `cpu_fault_led_o`, `selftest_led_o` and `fatal_o` are all 0.
- R2: The period P is sampled from `period_i` on the first clock edge after reset is released. Later changes of `period_i` have no effect until the next reset, including reloads caused by a clear.
- R3: A reload edge is any edge that applies reset sampling, a valid kick, a failover or a clear. Counting from a reload edge, if no valid kick arrives, the failover takes effect on the (P+1)th following edge. A valid kick captured on that (P+1)th edge prevents the failover and reloads instead.
- R4: A valid kick is a write with `wr_addr_i` = 4'h2 and `wr_data_i` = 16'hA5C3 from the processor in control (`wr_src_i` equal to `active_o`). It reloads the countdown to P.
- R5: Writes with a different data value, a different address, or from the disabled processor do not reload the countdown.
- R6: On the first expiry, `cpu_dis_o` becomes 2'b01, `active_o` becomes 1 and `cpu_fault_led_o` becomes 1. The countdown restarts from P for the standby processor. `cpu_dis_o` is never 2'b00.
- R7: An expiry while the standby is in control sets `cpu_dis_o` to 2'b11 and `fatal_o` to 1. In that state every bus write is ignored and the outputs hold until a clear.
- R8: A write to address 4'h5 from the processor in control with data bit 0 set lights `selftest_led_o`. The same write with bit 0 clear has no effect.
- R9: A clear pulse returns `cpu_dis_o` to 2'b10 and `active_o` to 0, clears all indicators and `fatal_o`, and reloads the countdown. A clear on the same edge as an expiry wins.
- R10: Once set, `cpu_fault_led_o` and `selftest_led_o` stay set through kicks and failovers until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CNT_W | Timeout period in cycles, sampled once after reset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_src_i | input | 1 | Issuing processor: 0 primary, 1 standby |
| wr_addr_i | input | ADDR_W | Register address of the write |
| wr_data_i | input | DATA_W | Write data |
| clr_i | input | 1 | Operator clear pulse |
| cpu_dis_o | output | 2 | Per-processor disable, bit 0 primary, bit 1 standby |
| active_o | output | 1 | Processor in control: 0 primary, 1 standby |
| cpu_fault_led_o | output | 1 | Sticky CPU-fault indicator |
| selftest_led_o | output | 1 | Sticky self-test fault indicator |
| fatal_o | output | 1 | Both processors have timed out |

## Verification
The assertions assume that `clr_i` is a pulse that does not need to be held. They also assume that `period_i` is a stable value when reset is released and that `wr_src_i` is meaningful only while `wr_en_i` is high. The bench drives every input on the falling clock edge. It sets the period before releasing reset and never writes and clears on the same edge. Timing is counted in edges from each reload, so the bench places kicks, foreign writes and clears exactly on the boundary edge that decides between reload and failover.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Supervisor states: which processor holds control, or none
  typedef enum logic [1:0] {
    SUP_PRI  = 2'd0,
    SUP_SEC  = 2'd1,
    SUP_DEAD = 2'd2
  } sup_state_e;

  localparam int unsigned NUM_CPU = 2;

endpackage

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter logic [ADDR_W-1:0] KICK_ADDR = 4'h2,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'h5,
  parameter logic [DATA_W-1:0] KICK_KEY  = 16'hA5C3
) (
  input  logic              wr_en_i,
  input  logic              wr_src_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        cpu_dis_i,
  output logic              kick_o,
  output logic              flag_o
);
  import wdt_pkg::*;

  logic [NUM_CPU-1:0] grant;
  logic               owner_wr;

  // One grant per processor: its write counts only while it is enabled
  for (genvar g = 0; g < NUM_CPU; g++) begin : g_grant
    assign grant[g] = wr_en_i && (wr_src_i == 1'(g)) && !cpu_dis_i[g];
  end

  assign owner_wr = |grant;

  always_comb begin
    kick_o = owner_wr && (wr_addr_i == KICK_ADDR) && (wr_data_i == KICK_KEY);
    flag_o = owner_wr && (wr_addr_i == FLAG_ADDR) && wr_data_i[0];
  end

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic             run_i,
  input  logic             kick_i,
  input  logic             clr_i,
  output logic             expire_o
);

  logic             init_q, init_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    init_d   = init_q;
    period_d = period_q;
    cnt_d    = cnt_q;
    expire_o = init_q && run_i && (cnt_q == '0) && !kick_i && !clr_i;
    if (!init_q) begin
      init_d   = 1'b1;
      period_d = period_i;
      cnt_d    = period_i;
    end else if (kick_i || clr_i || expire_o) begin
      cnt_d = period_q;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_en = !init_q || kick_i || clr_i || expire_o || (run_i && (cnt_q != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q   <= 1'b0;
      period_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (!init_q) begin
        init_q   <= init_d;
        period_q <= period_d;
      end
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  // R3
  tick_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && run_i && !kick_i && !clr_i && (cnt_q != '0))
      |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && (kick_i || clr_i)) |=> (cnt_q == period_q));

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire_i,
  input  logic       flag_i,
  input  logic       clr_i,
  output logic [1:0] cpu_dis_o,
  output logic       active_o,
  output logic       run_o,
  output logic       cpu_fault_o,
  output logic       selftest_o,
  output logic       fatal_o
);
  import wdt_pkg::*;

  sup_state_e state_q, state_d;
  logic       fault_q, fault_d;
  logic       st_q, st_d;
  logic       fatal_q, fatal_d;
  logic       upd_en;

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    st_d    = st_q;
    fatal_d = fatal_q;
    if (clr_i) begin
      state_d = SUP_PRI;
      fault_d = 1'b0;
      st_d    = 1'b0;
      fatal_d = 1'b0;
    end else begin
      if (expire_i) begin
        case (state_q)
          SUP_PRI: begin
            state_d = SUP_SEC;
            fault_d = 1'b1;
          end
          SUP_SEC: begin
            state_d = SUP_DEAD;
            fault_d = 1'b1;
            fatal_d = 1'b1;
          end
          default: ;
        endcase
      end
      if (flag_i) begin
        st_d = 1'b1;
      end
    end
  end

  assign upd_en = clr_i || expire_i || flag_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SUP_PRI;
      fault_q <= 1'b0;
      st_q    <= 1'b0;
      fatal_q <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      fault_q <= fault_d;
      st_q    <= st_d;
      fatal_q <= fatal_d;
    end
  end

  always_comb begin
    case (state_q)
      SUP_PRI: cpu_dis_o = 2'b10;
      SUP_SEC: cpu_dis_o = 2'b01;
      default: cpu_dis_o = 2'b11;
    endcase
  end

  assign active_o    = (state_q != SUP_PRI);
  assign run_o       = (state_q != SUP_DEAD);
  assign cpu_fault_o = fault_q;
  assign selftest_o  = st_q;
  assign fatal_o     = fatal_q;

  // R6
  first_failover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SUP_PRI && expire_i && !clr_i) |=> (state_q == SUP_SEC && fault_q));

  // R7
  fatal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fatal_q) |-> ($past(state_q) == SUP_SEC));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (state_q == SUP_PRI && !fault_q && !st_q && !fatal_q));

endmodule

// File: rtl/wdt_failover.sv
module wdt_failover #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-1:0] KICK_ADDR = 4'h2,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'h5,
  parameter logic [DATA_W-1:0] KICK_KEY  = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  period_i,
  input  logic              wr_en_i,
  input  logic              wr_src_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_i,
  output logic [1:0]        cpu_dis_o,
  output logic              active_o,
  output logic              cpu_fault_led_o,
  output logic              selftest_led_o,
  output logic              fatal_o
);

  logic kick;
  logic flag;
  logic expire;
  logic run;

  wdt_bus_decode #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .KICK_ADDR(KICK_ADDR),
    .FLAG_ADDR(FLAG_ADDR),
    .KICK_KEY (KICK_KEY)
  ) u_decode (
    .wr_en_i  (wr_en_i),
    .wr_src_i (wr_src_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .cpu_dis_i(cpu_dis_o),
    .kick_o   (kick),
    .flag_o   (flag)
  );

  wdt_countdown #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .period_i(period_i),
    .run_i   (run),
    .kick_i  (kick),
    .clr_i   (clr_i),
    .expire_o(expire)
  );

  wdt_supervisor u_sup (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire_i   (expire),
    .flag_i     (flag),
    .clr_i      (clr_i),
    .cpu_dis_o  (cpu_dis_o),
    .active_o   (active_o),
    .run_o      (run),
    .cpu_fault_o(cpu_fault_led_o),
    .selftest_o (selftest_led_o),
    .fatal_o    (fatal_o)
  );

  // R6
  one_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_dis_o != 2'b00);

  // R7
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_dis_o == 2'b11 && !clr_i) |=> (cpu_dis_o == 2'b11 && $stable(selftest_led_o)));

endmodule

// File: tb/wdt_failover_tb.sv
module wdt_failover_tb;

  localparam logic [15:0] TP   = 16'd20;
  localparam logic [15:0] KEY  = 16'hA5C3;
  localparam logic [3:0]  A_KICK = 4'h2;
  localparam logic [3:0]  A_FLAG = 4'h5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] period;
  logic        wr_en;
  logic        wr_src;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        clr;
  logic [1:0]  cpu_dis;
  logic        active;
  logic        fault_led;
  logic        st_led;
  logic        fatal;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  wdt_failover u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .period_i       (period),
    .wr_en_i        (wr_en),
    .wr_src_i       (wr_src),
    .wr_addr_i      (wr_addr),
    .wr_data_i      (wr_data),
    .clr_i          (clr),
    .cpu_dis_o      (cpu_dis),
    .active_o       (active),
    .cpu_fault_led_o(fault_led),
    .selftest_led_o (st_led),
    .fatal_o        (fatal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic src, input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_src = src; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_src = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  // Ends at the negedge following the period-sampling edge
  task automatic do_reset(input logic [15:0] p);
    rst_n = 1'b0; period = p;
    wr_en = 1'b0; wr_src = 1'b0; wr_addr = '0; wr_data = '0; clr = 1'b0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(TP);
    check("R1 dis", 32'(cpu_dis), 32'h2);
    check("R1 active", 32'(active), 0);
    check("R1 fault", 32'(fault_led), 0);
    check("R1 selftest", 32'(st_led), 0);
    check("R1 fatal", 32'(fatal), 0);
  endtask

  task automatic t_expiry();
    do_reset(TP);
    idle(TP);
    check("R3 before deadline", 32'(cpu_dis), 32'h2);
    idle(1);
    check("R3 at deadline", 32'(cpu_dis), 32'h1);
    check("R6 active", 32'(active), 1);
    check("R6 fault", 32'(fault_led), 1);
  endtask

  task automatic t_kick();
    do_reset(TP);
    for (int k = 0; k < 3; k++) begin
      idle(TP - 5);
      bus_wr(1'b0, A_KICK, KEY);
    end
    check("R4 periodic kicks", 32'(cpu_dis), 32'h2);
    idle(TP);
    bus_wr(1'b0, A_KICK, KEY);
    check("R3 last-edge kick", 32'(cpu_dis), 32'h2);
    idle(TP);
    check("R4 reload from last kick", 32'(cpu_dis), 32'h2);
    idle(1);
    check("R3 expiry after last kick", 32'(cpu_dis), 32'h1);
  endtask

  task automatic t_ignored();
    do_reset(TP);
    bus_wr(1'b0, A_KICK, KEY ^ 16'h0001);
    bus_wr(1'b0, 4'h3, KEY);
    bus_wr(1'b1, A_KICK, KEY);
    bus_wr(1'b0, A_FLAG, 16'h0002);
    check("R8 flag bit0 clear", 32'(st_led), 0);
    idle(TP - 4);
    check("R5 before deadline", 32'(cpu_dis), 32'h2);
    idle(1);
    check("R5 bad writes did not reload", 32'(cpu_dis), 32'h1);
  endtask

  task automatic t_chain();
    do_reset(TP);
    period = 16'd5;
    idle(TP);
    check("R2 period kept", 32'(cpu_dis), 32'h2);
    idle(1);
    check("R2 expiry at sampled period", 32'(cpu_dis), 32'h1);
    bus_wr(1'b0, A_KICK, KEY);
    idle(TP - 1);
    check("R6 restart for standby", 32'(cpu_dis), 32'h1);
    check("R6 not fatal yet", 32'(fatal), 0);
    idle(1);
    check("R7 both disabled", 32'(cpu_dis), 32'h3);
    check("R7 fatal", 32'(fatal), 1);
    bus_wr(1'b1, A_KICK, KEY);
    bus_wr(1'b0, A_FLAG, 16'h0001);
    bus_wr(1'b1, A_FLAG, 16'h0001);
    idle(3 * TP);
    check("R7 hold dis", 32'(cpu_dis), 32'h3);
    check("R7 writes ignored", 32'(st_led), 0);
    check("R7 hold fatal", 32'(fatal), 1);
    do_clear();
    check("R9 dis", 32'(cpu_dis), 32'h2);
    check("R9 active", 32'(active), 0);
    check("R9 fault", 32'(fault_led), 0);
    check("R9 fatal", 32'(fatal), 0);
    idle(TP);
    check("R2 clear reload uses sampled period", 32'(cpu_dis), 32'h2);
    idle(1);
    check("R9 expiry after clear", 32'(cpu_dis), 32'h1);
  endtask

  task automatic t_selftest();
    do_reset(TP);
    bus_wr(1'b0, A_FLAG, 16'h0001);
    check("R8 selftest set", 32'(st_led), 1);
    bus_wr(1'b0, A_KICK, KEY);
    idle(3);
    check("R10 selftest kept", 32'(st_led), 1);
    idle(TP - 2);
    check("R10 failover", 32'(cpu_dis), 32'h1);
    check("R10 selftest after failover", 32'(st_led), 1);
    bus_wr(1'b1, A_KICK, KEY);
    idle(5);
    check("R10 fault kept", 32'(fault_led), 1);
    do_clear();
    check("R9 selftest cleared", 32'(st_led), 0);
  endtask

  task automatic t_clear_race();
    do_reset(TP);
    idle(TP);
    do_clear();
    check("R9 clear beats expiry", 32'(cpu_dis), 32'h2);
    check("R9 no fault", 32'(fault_led), 0);
    idle(TP);
    check("R9 reload by clear", 32'(cpu_dis), 32'h2);
    idle(1);
    check("R9 expiry after race", 32'(cpu_dis), 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    period = TP;
    wr_en = 1'b0; wr_src = 1'b0; wr_addr = '0; wr_data = '0; clr = 1'b0;
    t_reset();
    t_expiry();
    t_kick();
    t_ignored();
    t_chain();
    t_selftest();
    t_clear_race();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule